// File: doc/BRIEF.md
# I2C Bus Status and Arbitration Monitor

This block sits beside an I2C controller and watches the bus. It takes the raw SCL and SDA pin levels and the level the controller itself wants on SDA. From these it keeps an 8-bit status word. The status word tracks five things: bus occupancy, byte completion, own-address hits, the direction bit of the calling address, and the acknowledge returned for each byte.

Its main job is to judge arbitration. The monitor compares what the controller drives with what the bus shows, and it watches the controller's start, repeated-start and stop requests against the bus state. The five loss causes all set one sticky flag. Completion, address hits and arbitration loss each set an interrupt-pending flag, which is gated by an enable input onto the interrupt line. Software reads the status word and clears its two sticky flags by writing ones. A write to the control address clears the address-hit flag.

Shifting data, generating clocks and decoding addresses happen elsewhere. Their results reach this block as level inputs and one-cycle pulses.

Top module: `i2c_stat_mon`

## Requirements
- R1: After reset every status bit reads 0 and `irq` is 0.
- R2: A START (SDA falling while SCL is high) sets the busy bit (bit 5), and a STOP (SDA rising while SCL is high) clears it. Both are seen on pins synchronized through two flops and one compare register, so a pin change shows in `rd_data` three clocks later.
- R3: The transfer-done bit (bit 7) is cleared on the first SCL rising edge of a byte. It is set on the SCL falling edge that ends the ninth clock of the byte.
- R4: The address-hit bit (bit 6) is set by a pulse on `addr_hit` and cleared by any write with `wr_addr`=1. When both occur in the same cycle, the set wins.
- R5: The direction bit (bit 2) takes the SDA level at the eighth SCL rise of the first byte after a START. The no-ack bit (bit 0) takes the SDA level at the ninth SCL rise of every byte, where 1 means no acknowledge.
- R6: Arbitration-lost (bit 4) is set when, in master mode, SDA reads low while `sda_drv_hi` is 1 during bits 1 to 8 of an address byte, or of a data byte with `xmit_en`=1.
- R7: Arbitration-lost is set when, in master mode with `xmit_en`=0, SDA reads low while `sda_drv_hi` is 1 at the ninth SCL rise of a data byte. The data bits of a received byte never set it.
- R8: Arbitration-lost is set by a `start_req` pulse while the bus is busy. The same pulse has no effect on an idle bus.
- R9: Arbitration-lost is set by an `rstart_req` pulse while `master_en` is 0. The same pulse has no effect in master mode.
- R10: Arbitration-lost is set by a STOP seen in master mode with no `stop_req` pulse since the last STOP. A requested STOP leaves it at 0.
- R11: The interrupt-pending bit (bit 1) is set whenever transfer-done is set, the address-hit pulse arrives, or arbitration is lost.
- R12: A write with `wr_addr`=0 clears bit 4 and bit 1 where the written bit is 1. Written zeros do nothing, and every other bit ignores the write. A set in the same cycle overrides the clear.
- R13: The status word is laid out from bit 7 down as transfer-done, address-hit, busy, arbitration-lost, reserved, direction, interrupt-pending, no-ack. Reserved bit 3 always reads 0.
- R14: `irq` equals interrupt-pending AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level |
| sda_drv_hi | input | 1 | Controller releases SDA (intends a high) |
| master_en | input | 1 | Controller is in master mode |
| xmit_en | input | 1 | Controller transmits data bytes |
| start_req | input | 1 | Pulse: controller requests a START |
| rstart_req | input | 1 | Pulse: controller requests a repeated START |
| stop_req | input | 1 | Pulse: controller requests a STOP |
| addr_hit | input | 1 | Pulse: calling address matched own address |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = status word, 1 = control register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a loss of arbitration on the acknowledge slot of a received byte. Reaching it takes a complete START, an address byte that the monitor must not judge on its ack, and eight received data bits driven low that must not count as a mismatch. Only then is the ninth clock reached, with the controller releasing SDA while the line is pulled low. The bench drives the pins bit by bit with tasks that hold each half SCL period for several clocks. A behavioural model, running on a delayed history of pin samples, predicts the status word on every clock so that the mid-byte states are checked too.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

  localparam int unsigned STAT_W = 8;

  localparam int B_XFER_DONE = 7;
  localparam int B_ADDR_HIT  = 6;
  localparam int B_BUSY      = 5;
  localparam int B_ARB_LOST  = 4;
  localparam int B_RSVD      = 3;
  localparam int B_DIR_RD    = 2;
  localparam int B_IRQ_PEND  = 1;
  localparam int B_NO_ACK    = 0;

  localparam logic [STAT_W-1:0] W1C_MASK =
    STAT_W'((1 << B_ARB_LOST) | (1 << B_IRQ_PEND));

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sda;
  } line_ev_t;

  typedef struct packed {
    logic done_set;
    logic done_clr;
    logic dir_cap;
    logic ack_cap;
  } bit_ev_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import i2c_stat_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_raw,
  input  logic     sda_raw,
  output line_ev_t ev
);

  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw_v;
  logic [NLINES-1:0] cur_v;
  logic [NLINES-1:0] prv_v;

  assign raw_v = {scl_raw, sda_raw};

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    logic [SYNC_STAGES-1:0] sh_q;
    logic [SYNC_STAGES-1:0] sh_d;
    logic                   prv_q;

    if (SYNC_STAGES == 1) begin : g_one
      always_comb sh_d = raw_v[l];
    end else begin : g_many
      always_comb sh_d = {sh_q[SYNC_STAGES-2:0], raw_v[l]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q  <= '1;
        prv_q <= 1'b1;
      end else begin
        sh_q  <= sh_d;
        prv_q <= sh_q[SYNC_STAGES-1];
      end
    end

    assign cur_v[l] = sh_q[SYNC_STAGES-1];
    assign prv_v[l] = prv_q;
  end

  logic scl_c, scl_p, sda_c, sda_p;
  assign scl_c = cur_v[1];
  assign scl_p = prv_v[1];
  assign sda_c = cur_v[0];
  assign sda_p = prv_v[0];

  always_comb begin
    ev.start = scl_c & scl_p & sda_p & ~sda_c;
    ev.stop  = scl_c & scl_p & ~sda_p & sda_c;
    ev.rise  = scl_c & ~scl_p;
    ev.fall  = ~scl_c & scl_p;
    ev.sda   = sda_c;
  end

endmodule

// File: rtl/i2c_bit_track.sv
module i2c_bit_track
  import i2c_stat_pkg::*;
#(
  parameter int unsigned BITS_PER_BYTE = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  line_ev_t ev,
  input  logic     master_en,
  input  logic     xmit_en,
  input  logic     sda_drv_hi,
  output bit_ev_t  bev,
  output logic     mismatch
);

  localparam int unsigned CLKS_PER_BYTE = BITS_PER_BYTE + 1;
  localparam int unsigned CNT_W         = $clog2(CLKS_PER_BYTE + 1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_DIR  = CNT_W'(BITS_PER_BYTE - 1);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BITS_PER_BYTE);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(CLKS_PER_BYTE);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;
  logic             cnt_en;

  logic data_slot, ack_slot, drive_bits, pulled_low;

  always_comb begin
    data_slot  = cnt_q < CNT_ACK;
    ack_slot   = cnt_q == CNT_ACK;
    drive_bits = master_en & (first_q | xmit_en);
    pulled_low = sda_drv_hi & ~ev.sda;
  end

  always_comb begin
    cnt_d        = cnt_q;
    first_d      = first_q;
    bev.done_set = 1'b0;
    bev.done_clr = 1'b0;
    bev.dir_cap  = 1'b0;
    bev.ack_cap  = 1'b0;
    mismatch     = 1'b0;
    if (ev.start || ev.stop) begin
      cnt_d   = CNT_ZERO;
      first_d = 1'b1;
    end else if (ev.rise) begin
      bev.done_clr = cnt_q == CNT_ZERO;
      bev.dir_cap  = first_q & (cnt_q == CNT_DIR);
      bev.ack_cap  = ack_slot;
      if (pulled_low) begin
        if (data_slot && drive_bits) begin
          mismatch = 1'b1;
        end
        if (ack_slot && master_en && !xmit_en && !first_q) begin
          mismatch = 1'b1;
        end
      end
      if (cnt_q < CNT_END) begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (ev.fall && (cnt_q == CNT_END)) begin
      bev.done_set = 1'b1;
      cnt_d        = CNT_ZERO;
      first_d      = 1'b0;
    end
  end

  assign cnt_en = (cnt_d != cnt_q) | (first_d != first_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_ZERO;
      first_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

endmodule

// File: rtl/i2c_arb_judge.sv
module i2c_arb_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic mismatch,
  input  logic bus_busy,
  input  logic master_en,
  input  logic start_req,
  input  logic rstart_req,
  input  logic stop_req,
  output logic arb_set
);

  logic stop_pend_q, stop_pend_d;
  logic cause_busy_start, cause_slave_rstart, cause_rogue_stop;

  always_comb begin
    cause_busy_start   = start_req & bus_busy;
    cause_slave_rstart = rstart_req & ~master_en;
    cause_rogue_stop   = stop_det & master_en & ~stop_pend_q;
    arb_set = mismatch | cause_busy_start | cause_slave_rstart | cause_rogue_stop;
  end

  always_comb begin
    stop_pend_d = stop_pend_q;
    if (stop_det) begin
      stop_pend_d = 1'b0;
    end else if (stop_req) begin
      stop_pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_pend_q <= 1'b0;
    end else if (stop_pend_d != stop_pend_q) begin
      stop_pend_q <= stop_pend_d;
    end
  end

endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_lvl,
  input  bit_ev_t           bev,
  input  logic              arb_set,
  input  logic              addr_hit,
  input  logic              stat_wr,
  input  logic              ctrl_wr,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] stat
);

  logic [STAT_W-1:0] set_v, clr_v, ld_v, ld_val;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              upd_en;

  always_comb begin
    set_v  = '0;
    clr_v  = '0;
    ld_v   = '0;
    ld_val = '0;

    set_v[B_XFER_DONE] = bev.done_set;
    clr_v[B_XFER_DONE] = bev.done_clr;

    set_v[B_ADDR_HIT]  = addr_hit;
    clr_v[B_ADDR_HIT]  = ctrl_wr;

    set_v[B_BUSY]      = start_det;
    clr_v[B_BUSY]      = stop_det;

    set_v[B_ARB_LOST]  = arb_set;

    set_v[B_IRQ_PEND]  = bev.done_set | addr_hit | arb_set;

    ld_v[B_DIR_RD]     = bev.dir_cap;
    ld_val[B_DIR_RD]   = sda_lvl;
    ld_v[B_NO_ACK]     = bev.ack_cap;
    ld_val[B_NO_ACK]   = sda_lvl;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    logic sw_clr;
    assign sw_clr = stat_wr & wr_data[i] & W1C_MASK[i];
    always_comb begin
      if (ld_v[i]) begin
        stat_d[i] = ld_val[i];
      end else if (set_v[i]) begin
        stat_d[i] = 1'b1;
      end else if (clr_v[i] || sw_clr) begin
        stat_d[i] = 1'b0;
      end else begin
        stat_d[i] = stat_q[i];
      end
    end
  end

  assign upd_en = |(stat_d ^ stat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (upd_en) begin
      stat_q <= stat_d;
    end
  end

  assign stat = stat_q;

endmodule

// File: rtl/i2c_stat_mon.sv
module i2c_stat_mon
  import i2c_stat_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned BITS_PER_BYTE = 8,
  parameter int unsigned RST_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              sda_drv_hi,
  input  logic              master_en,
  input  logic              xmit_en,
  input  logic              start_req,
  input  logic              rstart_req,
  input  logic              stop_req,
  input  logic              addr_hit,
  input  logic              irq_en,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq
);

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[RST_STAGES-1];

  line_ev_t lev;
  bit_ev_t  bev;
  logic     mismatch;
  logic     arb_set;
  logic     start_det, stop_det;
  logic     stat_wr, ctrl_wr;
  logic [STAT_W-1:0] stat;

  assign start_det = lev.start;
  assign stop_det  = lev.stop;
  assign stat_wr   = wr_en & ~wr_addr;
  assign ctrl_wr   = wr_en & wr_addr;

  i2c_line_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .scl_raw(scl_i),
    .sda_raw(sda_i),
    .ev     (lev)
  );

  i2c_bit_track #(
    .BITS_PER_BYTE(BITS_PER_BYTE)
  ) u_bits (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ev        (lev),
    .master_en (master_en),
    .xmit_en   (xmit_en),
    .sda_drv_hi(sda_drv_hi),
    .bev       (bev),
    .mismatch  (mismatch)
  );

  i2c_arb_judge u_arb (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .mismatch  (mismatch),
    .bus_busy  (stat[B_BUSY]),
    .master_en (master_en),
    .start_req (start_req),
    .rstart_req(rstart_req),
    .stop_req  (stop_req),
    .arb_set   (arb_set)
  );

  i2c_stat_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_lvl  (lev.sda),
    .bev      (bev),
    .arb_set  (arb_set),
    .addr_hit (addr_hit),
    .stat_wr  (stat_wr),
    .ctrl_wr  (ctrl_wr),
    .wr_data  (wr_data),
    .stat     (stat)
  );

  assign rd_data = stat;
  assign irq     = stat[B_IRQ_PEND] & irq_en;

endmodule

// File: rtl/i2c_stat_mon_chk.sv
module i2c_stat_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       irq_en,
  input logic       wr_en,
  input logic       wr_addr,
  input logic [7:0] wr_data,
  input logic       addr_hit,
  input logic       start_det,
  input logic       stop_det,
  input logic       arb_set
);

  logic stat_wr, ctrl_wr;
  assign stat_wr = wr_en & ~wr_addr;
  assign ctrl_wr = wr_en & wr_addr;

  a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> rd_data[5]);

  a_r2_idle_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !rd_data[5]);

  a_r4_hit_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !addr_hit) |=> !rd_data[6]);

  a_r4_hit_set: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> rd_data[6]);

  a_r11_pend_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    arb_set |=> (rd_data[1] && rd_data[4]));

  a_r12_loss_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wr_data[4] && !arb_set) |=> !rd_data[4]);

  a_r12_loss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] && !(stat_wr && wr_data[4])) |=> rd_data[4]);

  a_r13_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[3]);

  a_r14_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data[1] & irq_en));

endmodule

bind i2c_stat_mon i2c_stat_mon_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_data  (rd_data),
  .irq      (irq),
  .irq_en   (irq_en),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .addr_hit (addr_hit),
  .start_det(start_det),
  .stop_det (stop_det),
  .arb_set  (arb_set)
);

// File: tb/i2c_stat_mon_test.sv
`timescale 1ns/1ps
module i2c_stat_mon_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_pin = 1'b1, sda_pin = 1'b1, drv = 1'b1;
  logic       master_en = 1'b0, xmit_en = 1'b0;
  logic       start_req = 1'b0, rstart_req = 1'b0, stop_req = 1'b0;
  logic       addr_hit = 1'b0, irq_en = 1'b0;
  logic       wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_stat_mon uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_pin), .sda_i(sda_pin),
    .sda_drv_hi(drv), .master_en(master_en), .xmit_en(xmit_en),
    .start_req(start_req), .rstart_req(rstart_req), .stop_req(stop_req),
    .addr_hit(addr_hit), .irq_en(irq_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [1:0] hist[$];
  logic [7:0] m_stat;
  int         m_cnt;
  bit         m_first, m_spend;
  bit         cs, cd, ps, pd, e_start, e_stop, e_rise, e_fall;
  bit         mis, t_set, t_clr, lost, m_busy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{2'b11, 2'b11, 2'b11};
      m_stat = 8'h00; m_cnt = 0; m_first = 1'b1; m_spend = 1'b0;
    end else begin
      hist.push_front({scl_pin, sda_pin});
      cs = hist[2][1]; cd = hist[2][0];
      ps = hist[3][1]; pd = hist[3][0];
      void'(hist.pop_back());
      e_start = cs && ps && pd && !cd;
      e_stop  = cs && ps && !pd && cd;
      e_rise  = cs && !ps;
      e_fall  = !cs && ps;
      mis = 1'b0; t_set = 1'b0; t_clr = 1'b0;
      m_busy = m_stat[5];
      if (e_start || e_stop) begin
        m_cnt = 0; m_first = 1'b1;
      end else if (e_rise) begin
        if (m_cnt == 0) t_clr = 1'b1;
        if (m_cnt == 7 && m_first) m_stat[2] = cd;
        if (m_cnt == 8) m_stat[0] = cd;
        if (master_en && drv && !cd) begin
          if (m_cnt < 8 && (m_first || xmit_en)) mis = 1'b1;
          if (m_cnt == 8 && !xmit_en && !m_first) mis = 1'b1;
        end
        if (m_cnt < 9) m_cnt++;
      end else if (e_fall && m_cnt == 9) begin
        t_set = 1'b1; m_cnt = 0; m_first = 1'b0;
      end
      lost = mis || (start_req && m_busy) || (rstart_req && !master_en) ||
             (e_stop && master_en && !m_spend);
      if (e_stop) m_spend = 1'b0;
      else if (stop_req) m_spend = 1'b1;
      if (t_set) m_stat[7] = 1'b1; else if (t_clr) m_stat[7] = 1'b0;
      if (addr_hit) m_stat[6] = 1'b1; else if (wr_en && wr_addr) m_stat[6] = 1'b0;
      if (e_start) m_stat[5] = 1'b1; else if (e_stop) m_stat[5] = 1'b0;
      if (lost) m_stat[4] = 1'b1;
      else if (wr_en && !wr_addr && wr_data[4]) m_stat[4] = 1'b0;
      if (t_set || addr_hit || lost) m_stat[1] = 1'b1;
      else if (wr_en && !wr_addr && wr_data[1]) m_stat[1] = 1'b0;
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (rd_data !== m_stat || irq !== (m_stat[1] & irq_en)) begin
        fails++;
        $display("FAIL %s per-clock: actual stat=%02h irq=%0b expected stat=%02h irq=%0b",
          (rd_data[7] != m_stat[7]) ? "R3" : (rd_data[6] != m_stat[6]) ? "R4" :
          (rd_data[5] != m_stat[5]) ? "R2" : (rd_data[4] != m_stat[4]) ? "R6" :
          (rd_data[3] != m_stat[3]) ? "R13" : (rd_data[1] != m_stat[1]) ? "R11" :
          (rd_data[2] != m_stat[2] || rd_data[0] != m_stat[0]) ? "R5" : "R14",
          rd_data, irq, m_stat, m_stat[1] & irq_en);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string tag, input logic [7:0] exp_stat);
    logic exp_irq;
    repeat (4) @(negedge clk);
    exp_irq = exp_stat[1] & irq_en;
    tests++;
    if (rd_data !== exp_stat || irq !== exp_irq) begin
      fails++;
      $display("FAIL %s: actual stat=%02h irq=%0b expected stat=%02h irq=%0b",
               tag, rd_data, irq, exp_stat, exp_irq);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input logic d);
    sda_pin = b; drv = d;
    half(); scl_pin = 1'b1;
    half(); scl_pin = 1'b0;
    half();
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i], v[i]);
  endtask

  task automatic bus_start();
    sda_pin = 1'b1; scl_pin = 1'b1; drv = 1'b1; half();
    sda_pin = 1'b0; drv = 1'b0; half();
    scl_pin = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_pin = 1'b0; drv = 1'b0; half();
    scl_pin = 1'b1; half();
    sda_pin = 1'b1; drv = 1'b1; half();
  endtask

  task automatic reg_wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- scenario ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 reset state", 8'h00);

    // master transmits address 0xA5 (read), slave acks
    master_en = 1'b1; xmit_en = 1'b1;
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    chk("R8 start_req on idle bus ignored", 8'h00);
    bus_start();
    chk("R2 busy after START", 8'h20);
    send_byte(8'hA5);
    send_bit(1'b0, 1'b1);
    chk("R3 R5 done, dir=1, ack=0 after address byte", 8'hA6);
    irq_en = 1'b1;
    chk("R14 irq follows enable", 8'hA6);

    reg_wr(1'b0, 8'h00);
    chk("R12 zero write has no effect", 8'hA6);
    reg_wr(1'b0, 8'hFF);
    chk("R12 ones write clears only sticky bits", 8'hA4);

    // data byte 0x3C, no acknowledge
    send_bit(1'b0, 1'b0);
    chk("R3 done cleared mid-byte", 8'h24);
    for (int i = 6; i >= 0; i--) send_bit(8'h3C >> i & 1'b1, 8'h3C >> i & 1'b1);
    send_bit(1'b1, 1'b1);
    chk("R5 no-ack captured, dir kept", 8'hA7);
    reg_wr(1'b0, 8'h02);
    chk("R12 pending cleared by write", 8'hA5);

    // transmit mismatch
    send_bit(1'b0, 1'b1);
    chk("R6 transmit mismatch sets loss", 8'h37);
    master_en = 1'b0;
    for (int i = 0; i < 7; i++) send_bit(1'b1, 1'b1);
    send_bit(1'b0, 1'b1);
    chk("R6 R11 loss sticky through byte", 8'hB6);
    reg_wr(1'b0, 8'h12);
    chk("R12 loss cleared", 8'hA4);

    rstart_req = 1'b1; @(negedge clk); rstart_req = 1'b0;
    chk("R9 repeated start in slave mode", 8'hB6);
    reg_wr(1'b0, 8'h12);

    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    chk("R8 start_req while busy", 8'hB6);
    reg_wr(1'b0, 8'h12);
    chk("R12 cleared again", 8'hA4);

    // requested stop
    master_en = 1'b1;
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    bus_stop();
    chk("R10 requested STOP, R2 idle", 8'h04);

    // master receiver: address 0x51, then data byte with ack-slot mismatch
    xmit_en = 1'b0;
    bus_start();
    send_byte(8'h51);
    send_bit(1'b0, 1'b1);
    chk("R7 address ack slot not judged", 8'hA6);
    reg_wr(1'b0, 8'h02);
    for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b1);
    chk("R7 received data bits not judged", 8'h24);
    send_bit(1'b0, 1'b1);
    chk("R7 receive ack mismatch sets loss", 8'hB6);
    reg_wr(1'b0, 8'h12);

    // unrequested stop
    bus_stop();
    chk("R10 unrequested STOP", 8'h16);
    reg_wr(1'b0, 8'h12);
    chk("R12 cleared after stop", 8'h04);

    // address hit
    addr_hit = 1'b1; @(negedge clk); addr_hit = 1'b0;
    chk("R4 R11 address hit", 8'h46);
    reg_wr(1'b0, 8'h40);
    chk("R12 status write ignores hit bit", 8'h46);
    reg_wr(1'b1, 8'h00);
    chk("R4 control write clears hit", 8'h06);
    reg_wr(1'b0, 8'h02);
    addr_hit = 1'b1; wr_en = 1'b1; wr_addr = 1'b1;
    @(negedge clk);
    addr_hit = 1'b0; wr_en = 1'b0; wr_addr = 1'b0;
    chk("R4 set wins over control write", 8'h46);
    reg_wr(1'b1, 8'h00);
    reg_wr(1'b0, 8'h02);

    rstart_req = 1'b1; @(negedge clk); rstart_req = 1'b0;
    chk("R9 repeated start in master mode ignored", 8'h04);

    master_en = 1'b0;
    rstart_req = 1'b1; wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h12;
    @(negedge clk);
    rstart_req = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    chk("R12 set wins over W1C", 8'h16);
    reg_wr(1'b0, 8'h12);
    irq_en = 1'b0;
    chk("R13 reserved bit stays zero", 8'h04);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule